// File: doc/BRIEF.md
# Comparator Event and Input Routing Controller

This block is the synchronous control logic that sits beside an analog comparator. It brings the comparator's asynchronous result into the clock domain through a short flip-flop chain and exposes it as a read-only status bit. A two-bit trigger field selects whether a toggle, a falling edge or a rising edge of that synchronized result sets a sticky event flag. The flag raises an interrupt request when the local enable and the chip-wide enable also allow it.

The block also drives the routing controls for both comparator inputs. A reference-select bit picks the internal reference or the dedicated positive pin. A routing-enable bit, a converter-busy input and a channel field together pick the dedicated negative pin or one of the converter channels. A small byte-wide register window holds the control fields. It also holds a digital-input-disable mask that forces the readback of the analog pins to zero.

Software clears the flag by writing a one to it. The interrupt controller clears it with an acknowledge pulse.

Top module: `cmpx_ctrl`

## Requirements
- R1: After reset every control field, the event flag, the input-disable mask, the interrupt request and the pin readback are zero, and the negative input is routed to the dedicated pin.
- R2: The status bit (address 0, bit 5) shows the comparator input through a two-stage synchronizer. With the address held at 0, a change of the input is absent from the read data two clock edges later and present three clock edges later (read data is registered).
- R3: The trigger field (address 0, bits 1:0) sets the event flag (address 0, bit 4) as follows: 00 on any change of the synchronized output, 10 on a falling edge only, 11 on a rising edge only.
- R4: Writing a one to bit 4 of address 0 clears the flag. Writing a zero there leaves it unchanged.
- R5: A one-cycle pulse on `irq_ack` clears the flag.
- R6: When an edge event and a write-one-to-clear reach the flag in the same cycle, the flag ends up set.
- R7: `irq` is one, one cycle later, exactly when the flag, the interrupt enable (address 0, bit 3) and `glob_ie` are all one.
- R8: Bits 2 and 7 of address 0 always read as zero, even after a one is written to them.
- R9: `pos_use_ref` follows the reference-select bit (address 0, bit 6): one selects the internal reference, zero the dedicated positive pin.
- R10: With the routing enable (address 1, bit 7) at zero or `conv_en` at one, `neg_use_chan` is zero and `neg_chan` is zero. Otherwise `neg_use_chan` is one and `neg_chan` equals the channel field (address 1, bits 1:0), 00 through 11 selecting channels 0 through 3.
- R11: Each set bit of the disable mask (address 2, bits 5:0) forces the matching bit of `pin_rd` to zero, and clear bits pass `pin_raw` through. Bits 7:6 of address 2 read as zero.
- R12: Trigger setting 01 never sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_raw | input | 1 | Asynchronous comparator result |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the address of the previous cycle |
| glob_ie | input | 1 | Chip-wide interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge pulse for this source |
| conv_en | input | 1 | Converter enabled; blocks channel routing |
| pin_raw | input | NUM_PINS | Raw digital values of the analog-capable pins |
| pin_rd | output | NUM_PINS | Masked pin readback |
| irq | output | 1 | Interrupt request |
| pos_use_ref | output | 1 | Positive input uses the internal reference |
| neg_use_chan | output | 1 | Negative input uses a converter channel |
| neg_chan | output | CHAN_W | Selected converter channel |

## Verification
Every cycle the assertions check the gating of the interrupt request, that the flag rises only after a detected edge and never under trigger setting 01, that an acknowledge without a coincident edge leaves the flag clear, that channel routing never happens while the converter is enabled, and that pin readback never shows a one the pin did not carry. The exact synchronizer latency, the decoding of each trigger setting against chosen input sequences, write-one-to-clear semantics, the set-over-clear tie, the reserved read-zero bits and the full routing table are shown only by the bench's directed and randomized scenarios.

// File: rtl/cmpx_pkg.sv
package cmpx_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    TRIG_TOGGLE = 2'b00,
    TRIG_RSVD   = 2'b01,
    TRIG_FALL   = 2'b10,
    TRIG_RISE   = 2'b11
  } trig_mode_e;

  // register addresses
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_ROUTE = 2'd1;
  localparam logic [ADDR_W-1:0] A_MASK = 2'd2;

  // control register bit positions
  localparam int B_MODE = 0;
  localparam int B_IE   = 3;
  localparam int B_FLAG = 4;
  localparam int B_OUT  = 5;
  localparam int B_REF  = 6;

  // routing register bit positions
  localparam int B_CHAN  = 0;
  localparam int B_ROUTE = 7;
endpackage

// File: rtl/cmpx_sync.sv
module cmpx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cmpx_evt.sv
module cmpx_evt
  import cmpx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_in,
  input  trig_mode_e mode,
  input  logic       clr,
  output logic       evt,
  output logic       flag_q
);
  logic prev_q;
  logic rise_w;
  logic fall_w;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_in;
  end

  assign rise_w = sync_in & ~prev_q;
  assign fall_w = ~sync_in & prev_q;

  always_comb begin
    unique case (mode)
      TRIG_TOGGLE: evt = rise_w | fall_w;
      TRIG_FALL:   evt = fall_w;
      TRIG_RISE:   evt = rise_w;
      default:     evt = 1'b0;
    endcase
  end

  // an edge event wins over a clear arriving in the same cycle
  always_ff @(posedge clk) begin
    if (rst)      flag_q <= 1'b0;
    else if (evt) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end
endmodule

// File: rtl/cmpx_insel.sv
module cmpx_insel #(
  parameter int CHAN_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_sel,
  input  logic              route_en,
  input  logic              conv_en,
  input  logic [CHAN_W-1:0] chan,
  output logic              pos_use_ref,
  output logic              neg_use_chan,
  output logic [CHAN_W-1:0] neg_chan
);
  logic use_chan_w;

  assign use_chan_w = route_en & ~conv_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_use_ref  <= 1'b0;
      neg_use_chan <= 1'b0;
      neg_chan     <= '0;
    end else begin
      pos_use_ref  <= ref_sel;
      neg_use_chan <= use_chan_w;
      neg_chan     <= use_chan_w ? chan : '0;
    end
  end
endmodule

// File: rtl/cmpx_ctrl.sv
module cmpx_ctrl
  import cmpx_pkg::*;
#(
  parameter int NUM_PINS    = 6,
  parameter int CHAN_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmp_raw,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                glob_ie,
  input  logic                irq_ack,
  input  logic                conv_en,
  input  logic [NUM_PINS-1:0] pin_raw,
  output logic [NUM_PINS-1:0] pin_rd,
  output logic                irq,
  output logic                pos_use_ref,
  output logic                neg_use_chan,
  output logic [CHAN_W-1:0]   neg_chan
);
  trig_mode_e          mode_q;
  logic                ie_q;
  logic                ref_q;
  logic                route_q;
  logic [CHAN_W-1:0]   chan_q;
  logic [NUM_PINS-1:0] mask_q;
  logic                sync_out;
  logic                evt;
  logic                flag_q;
  logic                sw_clr;
  logic [DATA_W-1:0]   rd_mux;

  cmpx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (cmp_raw),
    .q_sync  (sync_out)
  );

  assign sw_clr = bus_wr && (bus_addr == A_CTRL) && bus_wdata[B_FLAG];

  cmpx_evt u_evt (
    .clk     (clk),
    .rst     (rst),
    .sync_in (sync_out),
    .mode    (mode_q),
    .clr     (sw_clr | irq_ack),
    .evt     (evt),
    .flag_q  (flag_q)
  );

  cmpx_insel #(.CHAN_W(CHAN_W)) u_insel (
    .clk          (clk),
    .rst          (rst),
    .ref_sel      (ref_q),
    .route_en     (route_q),
    .conv_en      (conv_en),
    .chan         (chan_q),
    .pos_use_ref  (pos_use_ref),
    .neg_use_chan (neg_use_chan),
    .neg_chan     (neg_chan)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= TRIG_TOGGLE;
      ie_q    <= 1'b0;
      ref_q   <= 1'b0;
      route_q <= 1'b0;
      chan_q  <= '0;
      mask_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL: begin
          mode_q <= trig_mode_e'(bus_wdata[B_MODE +: 2]);
          ie_q   <= bus_wdata[B_IE];
          ref_q  <= bus_wdata[B_REF];
        end
        A_ROUTE: begin
          chan_q  <= bus_wdata[B_CHAN +: CHAN_W];
          route_q <= bus_wdata[B_ROUTE];
        end
        A_MASK: mask_q <= bus_wdata[NUM_PINS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CTRL: begin
        rd_mux[B_MODE +: 2] = mode_q;
        rd_mux[B_IE]        = ie_q;
        rd_mux[B_FLAG]      = flag_q;
        rd_mux[B_OUT]       = sync_out;
        rd_mux[B_REF]       = ref_q;
      end
      A_ROUTE: begin
        rd_mux[B_CHAN +: CHAN_W] = chan_q;
        rd_mux[B_ROUTE]          = route_q;
      end
      A_MASK:  rd_mux[NUM_PINS-1:0] = mask_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      pin_rd    <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= rd_mux;
      pin_rd    <= pin_raw & ~mask_q;
      irq       <= flag_q & ie_q & glob_ie;
    end
  end
endmodule

// File: rtl/cmpx_chk.sv
module cmpx_chk #(
  parameter int NUM_PINS = 6,
  parameter int CHAN_W   = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                glob_ie,
  input logic                irq_ack,
  input logic                conv_en,
  input logic [NUM_PINS-1:0] pin_raw,
  input logic [NUM_PINS-1:0] pin_rd,
  input logic                irq,
  input logic                neg_use_chan,
  input logic [CHAN_W-1:0]   neg_chan,
  input logic [1:0]          mode,
  input logic                evt,
  input logic                flag
);
  // R7: a request needs the flag and the chip-wide enable one cycle earlier
  p_irq_gate_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(flag) && $past(glob_ie)));

  // R3: the flag only rises after a detected edge
  p_flag_src_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(evt));

  // R12: the reserved trigger setting never raises the flag
  p_rsvd_mode_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> ($past(mode) != 2'b01));

  // R5: an acknowledge without a coincident edge leaves the flag clear
  p_ack_clear_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(irq_ack) && !$past(evt)) |-> !flag);

  // R10: no channel routing while the converter runs
  p_route_block_r10: assert property (@(posedge clk) disable iff (rst)
    neg_use_chan |-> !$past(conv_en));

  // R10: channel index parked at zero when not routed
  p_chan_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !neg_use_chan |-> (neg_chan == '0));

  // R11: readback never shows a one the pin did not carry
  p_pin_mask_r11: assert property (@(posedge clk) disable iff (rst)
    ((pin_rd & ~$past(pin_raw)) == '0));
endmodule

bind cmpx_ctrl cmpx_chk #(.NUM_PINS(NUM_PINS), .CHAN_W(CHAN_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .glob_ie      (glob_ie),
  .irq_ack      (irq_ack),
  .conv_en      (conv_en),
  .pin_raw      (pin_raw),
  .pin_rd       (pin_rd),
  .irq          (irq),
  .neg_use_chan (neg_use_chan),
  .neg_chan     (neg_chan),
  .mode         (mode_q),
  .evt          (evt),
  .flag         (flag_q)
);

// File: tb/test_cmpx_ctrl.sv
`timescale 1ns/1ps
module test_cmpx_ctrl;
  localparam int NP = 6;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmp_raw = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic          glob_ie = 1'b0;
  logic          irq_ack = 1'b0;
  logic          conv_en = 1'b0;
  logic [NP-1:0] pin_raw = '0;
  logic [NP-1:0] pin_rd;
  logic          irq;
  logic          pos_use_ref;
  logic          neg_use_chan;
  logic [CW-1:0] neg_chan;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cmpx_ctrl #(.NUM_PINS(NP), .CHAN_W(CW), .SYNC_STAGES(2)) i_cmpx_ctrl (
    .clk(clk), .rst(rst), .cmp_raw(cmp_raw), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .glob_ie(glob_ie), .irq_ack(irq_ack), .conv_en(conv_en),
    .pin_raw(pin_raw), .pin_rd(pin_rd), .irq(irq),
    .pos_use_ref(pos_use_ref), .neg_use_chan(neg_use_chan), .neg_chan(neg_chan)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic hit(input logic [1:0] m, input logic o, input logic n);
    case (m)
      2'b00: return o != n;
      2'b10: return o & ~n;
      2'b11: return ~o & n;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [CW:0] route(input logic en, input logic cv, input logic [CW-1:0] ch);
    return (en && !cv) ? {1'b1, ch} : '0;
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic       cur;
    void'($urandom(32'd4242));
    cycles(3);
    rst = 1'b0;
    cycles(1);

    // R1 reset state
    rd(2'd0, d); check("R1 ctrl", d, 8'h00);
    rd(2'd1, d); check("R1 route", d, 8'h00);
    rd(2'd2, d); check("R1 mask", d, 8'h00);
    check("R1 irq", irq, 0);
    check("R1 pin_rd", pin_rd, 0);
    check("R1 neg", {neg_use_chan, neg_chan}, 0);

    // R2 synchronizer latency, address held at 0
    @(negedge clk); bus_addr = 2'd0;
    @(negedge clk); cmp_raw = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R2 two edges", bus_rdata[5], 0);
    @(negedge clk);
    check("R2 three edges", bus_rdata[5], 1);
    cur = 1'b1;
    wr(2'd0, 8'h10);

    // R8 reserved bits read zero
    wr(2'd0, 8'h84); rd(2'd0, d);
    check("R8 bit2", d[2], 0); check("R8 bit7", d[7], 0);

    // R3 / R12 randomized trigger decoding
    for (int i = 0; i < 48; i++) begin
      logic [1:0] m;
      logic       nv;
      m  = 2'($urandom_range(0, 3));
      nv = 1'($urandom_range(0, 1));
      wr(2'd0, {3'b000, 1'b1, 2'b00, m});
      @(negedge clk); cmp_raw = nv;
      cycles(5);
      rd(2'd0, d);
      if (m == 2'b01) check("R12 reserved mode", d[4], 0);
      else            check("R3 trigger", d[4], hit(m, cur, nv));
      check("R2 status", d[5], nv);
      cur = nv;
    end

    // R12 directed: both edges in reserved mode
    wr(2'd0, 8'h11);
    @(negedge clk); cmp_raw = ~cur; cycles(5);
    @(negedge clk); cmp_raw = cur;  cycles(5);
    rd(2'd0, d); check("R12 both edges", d[4], 0);

    // R3 directed: fall mode ignores a rise, catches a fall
    wr(2'd0, 8'h12);
    @(negedge clk); cmp_raw = 1'b0; cycles(5);
    wr(2'd0, 8'h12);
    @(negedge clk); cmp_raw = 1'b1; cycles(5);
    rd(2'd0, d); check("R3 fall ignores rise", d[4], 0);
    @(negedge clk); cmp_raw = 1'b0; cycles(5);
    rd(2'd0, d); check("R3 fall sets", d[4], 1);
    cur = 1'b0;

    // R4 write zero keeps, write one clears
    wr(2'd0, 8'h02); rd(2'd0, d); check("R4 write zero keeps", d[4], 1);
    wr(2'd0, 8'h12); rd(2'd0, d); check("R4 write one clears", d[4], 0);

    // R7 interrupt gating; mode rise, set flag
    wr(2'd0, 8'h03);
    @(negedge clk); cmp_raw = 1'b1; cycles(5); cur = 1'b1;
    check("R7 ie off", irq, 0);
    wr(2'd0, 8'h0B); cycles(2);
    check("R7 global off", irq, 0);
    @(negedge clk); glob_ie = 1'b1; cycles(2);
    check("R7 all on", irq, 1);

    // R5 acknowledge clears
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    cycles(2);
    check("R5 irq after ack", irq, 0);
    rd(2'd0, d); check("R5 flag after ack", d[4], 0);
    @(negedge clk); glob_ie = 1'b0;

    // R6 set wins over write-one-clear in the same cycle
    wr(2'd0, 8'h00);
    @(negedge clk); cmp_raw = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_addr = 2'd0; bus_wr = 1'b1; bus_wdata = 8'h10;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
    cur = 1'b0;
    rd(2'd0, d); check("R6 set beats clear", d[4], 1);
    wr(2'd0, 8'h10);

    // R9 positive input select
    wr(2'd0, 8'h40); cycles(2); check("R9 ref on", pos_use_ref, 1);
    rd(2'd0, d); check("R9 readback", d[6], 1);
    wr(2'd0, 8'h00); cycles(2); check("R9 ref off", pos_use_ref, 0);

    // R10 randomized negative routing
    for (int i = 0; i < 24; i++) begin
      logic          en;
      logic          cv;
      logic [CW-1:0] ch;
      en = 1'($urandom_range(0, 1));
      cv = 1'($urandom_range(0, 1));
      ch = CW'($urandom_range(0, 3));
      @(negedge clk); conv_en = cv;
      wr(2'd1, {en, 5'b0, ch});
      cycles(2);
      check("R10 route", {neg_use_chan, neg_chan}, route(en, cv, ch));
    end
    @(negedge clk); conv_en = 1'b0;
    wr(2'd1, 8'h83); cycles(2);
    check("R10 channel 3", {neg_use_chan, neg_chan}, 3'b111);
    @(negedge clk); conv_en = 1'b1; cycles(2);
    check("R10 converter on", {neg_use_chan, neg_chan}, 3'b000);
    @(negedge clk); conv_en = 1'b0;

    // R11 pin masking
    for (int i = 0; i < 16; i++) begin
      logic [NP-1:0] mk;
      logic [NP-1:0] pv;
      mk = NP'($urandom);
      pv = NP'($urandom);
      wr(2'd2, {2'b11, mk});
      @(negedge clk); pin_raw = pv;
      cycles(2);
      check("R11 mask", pin_rd, pv & ~mk);
      rd(2'd2, d);
      check("R11 upper zero", d, {2'b00, mk});
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule